// File: doc/BRIEF.md
# Single-Wire Register Access Master

This block is the host end of a half-duplex, one-wire register link. A client hands it one request at a time: read or write, a 5-bit register address and, for writes, one data byte. The block serialises a frame onto the shared line. Every bit lasts a programmable number of clocks. The opening three-bit pattern tells the far end how long one bit is. The block releases the line at each turnaround point and collects whatever the far end returns. It ends the frame with a single completion pulse that carries the read byte and an error flag.

Between frames the same wire carries interrupts from the far end. While the master is idle, it watches the synchronised line for a move to the programmed active level and reports each one as a single-cycle event. The idle level of the line is always the inverse of the active interrupt level, so the interrupt polarity setting also chooses the start pattern.

Top module: `swire_master`

## Requirements
- R1: After reset, `req_ready` is 1, and `line_oe`, `done`, and `irq_event` are 0.
- R2: Let A be the active interrupt level (`irq_act_high`). Frame bits 0 to 2 are driven as A, not A, A. This gives 1,0,1 when A=1 and 0,1,0 when A=0.
- R3: Bits 3 to 5 carry the operation code, 1,1,0 for a read or 0,1,1 for a write. Bits 6 to 10 carry the address, most significant bit first. All of these bits are driven.
- R4: The line is released (`line_oe`=0) at bit 11, on every bit of a read from bit 11 onward, and on bits 22 to 26 of a write.
- R5: On a write, bits 12 to 19 drive the data byte most significant bit first. Bits 20 and 21 drive P and then not P. P is 1 when the operation, address and data fields together hold an odd number of ones.
- R6: On a read, bits 12 to 21 are sampled near the centre of each bit. The first eight form `done_rdata`, most significant bit first. `done_err` is 1 unless the last two equal P and not P, with P computed over the received data.
- R7: On a write, bits 23 and 24 are sampled. `done_err` is 1 unless they equal the P and not P that were sent. `done_rdata` is 0 after a write.
- R8: A read frame is 24 bits long and a write frame is 27 bits long. The last two bits of each are released guard bits. `done` is a one-cycle pulse exactly (frame length × bit period) clocks after the accepting edge. `req_ready` is 0 from the accepting edge until the `done` cycle and is 1 again in that cycle.
- R9: The bit period is taken from `bit_period` when a request is accepted. Values below 4 are treated as 4, and values above 1024 are treated as 1024.
- R10: While idle, each move of the line to the active level produces exactly one single-cycle `irq_event`. Line activity during a frame produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_period | input | 11 | Clocks per bit, clamped to 4..1024, captured on accept |
| irq_act_high | input | 1 | 1: interrupt active high (idle low); 0: active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Master idle, request taken on valid and ready |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 5 | Register address |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | 8 | Read byte, valid with done |
| done_err | output | 1 | Parity or acknowledge mismatch, valid with done |
| irq_event | output | 1 | One-cycle interrupt report |
| line_in | input | 1 | Level seen on the wire |
| line_oe | output | 1 | Master drives the wire |
| line_out | output | 1 | Level driven when line_oe is 1 |

## Verification
A slip in the bit position counter or in the role decode shows on the very next bit centre. At that point `line_oe` or `line_out` disagrees with the expected field pattern. A wrong bit-counter limit shifts every later bit centre within one bit and moves the `done` pulse off its exact cycle. A corrupted receive shift register or parity term shows only at `done`, as a wrong byte or a wrong `done_err`. For that reason, frames with deliberately broken parity and acknowledge bits are run alongside clean ones. A monitor enable left on during frames shows as extra `irq_event` pulses during read data.

// File: rtl/swire_pkg.sv
// Shared constants and the per-position bit role decode for the
// single-wire register access master. Frame positions are fixed by the
// protocol; only timing is parameterised in the modules.
package swire_pkg;

    localparam int POS_W   = 5;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int TX_W    = 22;              // start3 op3 addr5 guard1 data8 par2
    localparam int RX_W    = DATA_W + 2;      // data plus two check bits

    localparam logic [2:0] OP_RD = 3'b110;
    localparam logic [2:0] OP_WR = 3'b011;

    localparam logic [POS_W-1:0] POS_GUARD_TURN = 5'd11;
    localparam logic [POS_W-1:0] POS_GUARD_WR   = 5'd22;
    localparam logic [POS_W-1:0] POS_ACK_FIRST  = 5'd23;
    localparam logic [POS_W-1:0] POS_ACK_LAST   = 5'd24;
    localparam logic [POS_W-1:0] POS_LAST_RD    = 5'd23;
    localparam logic [POS_W-1:0] POS_LAST_WR    = 5'd26;

    typedef enum logic [1:0] {
        ROLE_DRIVE,
        ROLE_RELEASE,
        ROLE_SAMPLE
    } bit_role_t;

    // Decide who owns the wire at a given frame position.
    function automatic bit_role_t role_at(input logic [POS_W-1:0] pos,
                                          input logic             is_wr);
        if (pos < POS_GUARD_TURN)  return ROLE_DRIVE;
        if (pos == POS_GUARD_TURN) return ROLE_RELEASE;
        if (pos < POS_GUARD_WR)    return is_wr ? ROLE_DRIVE : ROLE_SAMPLE;
        if (is_wr && pos >= POS_ACK_FIRST && pos <= POS_ACK_LAST)
            return ROLE_SAMPLE;
        return ROLE_RELEASE;
    endfunction

endpackage

// File: rtl/swire_bit_timer.sv
// Bit period timer. Captures a clamped period when a frame is loaded and
// counts clocks inside each bit, flagging the bit centre and the last
// clock of the bit. Assumes load and run are never both high.
module swire_bit_timer #(
    parameter int PER_W   = 11,
    parameter int PER_MIN = 4,
    parameter int PER_MAX = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PER_W-1:0] period_in,
    input  logic             run,
    output logic             bit_mid,
    output logic             bit_last
);

    localparam logic [PER_W-1:0] MIN_V = PER_W'(PER_MIN);
    localparam logic [PER_W-1:0] MAX_V = PER_W'(PER_MAX);

    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] per_clamped;

    // Restrict the requested period to the supported window.
    always_comb begin
        if (period_in < MIN_V)      per_clamped = MIN_V;
        else if (period_in > MAX_V) per_clamped = MAX_V;
        else                        per_clamped = period_in;
    end

    // Period capture and in-bit clock counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= MIN_V;
            cnt_q <= '0;
        end else if (load) begin
            per_q <= per_clamped;
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= bit_last ? '0 : cnt_q + PER_W'(1);
        end
    end

    assign bit_mid  = run && (cnt_q == (per_q >> 1));
    assign bit_last = run && (cnt_q == per_q - PER_W'(1));

    AST_PERIOD_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q >= MIN_V) && (per_q <= MAX_V)); // R9
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < per_q); // R9

endmodule

// File: rtl/swire_line_rx.sv
// Line receiver. Brings the asynchronous wire level into the clock domain
// through a flop chain and, while monitoring is enabled, turns each move
// to the active interrupt level into a one-cycle event.
module swire_line_rx #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic act_lvl,
    input  logic monitor,
    output logic line_s,
    output logic irq_event
);

    logic [SYNC_STAGES:0] chain_q;
    logic                 prev_s;

    // Synchroniser chain with one extra stage kept for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {(SYNC_STAGES+1){~act_lvl}};
        else        chain_q <= {chain_q[SYNC_STAGES-1:0], line_in};
    end

    assign line_s = chain_q[SYNC_STAGES-1];
    assign prev_s = chain_q[SYNC_STAGES];

    // Report a transition into the active level while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_event <= 1'b0;
        else        irq_event <= monitor && (line_s == act_lvl) && (prev_s != act_lvl);
    end

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_event |=> !irq_event); // R10

endmodule

// File: rtl/swire_frame_ctl.sv
// Frame sequencer. Accepts a request while idle, builds the outgoing bit
// vector with its parity, walks the frame positions on the timer's bit
// boundaries, shifts in sampled bits at bit centres and issues the
// completion pulse with read data and error status. Assumes the timer is
// loaded on the accepting cycle.
module swire_frame_ctl
    import swire_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              act_lvl,
    input  logic              line_s,
    input  logic              bit_mid,
    input  logic              bit_last,
    output logic              req_ready,
    output logic              timer_load,
    output logic              timer_run,
    output logic              line_oe,
    output logic              line_out,
    output logic              done,
    output logic [DATA_W-1:0] done_rdata,
    output logic              done_err
);

    typedef enum logic {ST_IDLE, ST_RUN} fst_t;

    fst_t             st_q;
    logic [POS_W-1:0] pos_q;
    logic             wr_q;
    logic [TX_W-1:0]  tx_q;
    logic [TX_W-1:0]  tx_sh;
    logic [RX_W-1:0]  rx_q;
    logic             accept;
    logic             at_end;
    logic [2:0]       op_new;
    logic [DATA_W-1:0] data_new;
    logic             par_new;
    logic             rd_par;
    bit_role_t        role;

    assign accept   = req_valid && (st_q == ST_IDLE);
    assign op_new   = req_write ? OP_WR : OP_RD;
    assign data_new = req_write ? req_wdata : '0;
    assign par_new  = ^{op_new, req_addr, data_new};
    assign role     = role_at(pos_q, wr_q);
    assign at_end   = bit_last && (pos_q == (wr_q ? POS_LAST_WR : POS_LAST_RD));
    assign rd_par   = ^{tx_q[18:11], rx_q[RX_W-1:2]};

    // Frame state, position and outgoing vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            pos_q <= '0;
            wr_q  <= 1'b0;
            tx_q  <= '0;
        end else if (accept) begin
            st_q  <= ST_RUN;
            pos_q <= '0;
            wr_q  <= req_write;
            tx_q  <= {act_lvl, ~act_lvl, act_lvl, op_new, req_addr, 1'b0,
                      data_new, par_new, ~par_new};
        end else if (st_q == ST_RUN && bit_last) begin
            if (at_end) begin
                st_q  <= ST_IDLE;
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + POS_W'(1);
            end
        end
    end

    // Receive shift register, fed at the centre of sampled bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       rx_q <= '0;
        else if (accept)  rx_q <= '0;
        else if (st_q == ST_RUN && bit_mid && role == ROLE_SAMPLE)
            rx_q <= {rx_q[RX_W-2:0], line_s};
    end

    // Completion pulse with the frame's result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            done_rdata <= '0;
            done_err   <= 1'b0;
        end else begin
            done <= (st_q == ST_RUN) && at_end;
            if (st_q == ST_RUN && at_end) begin
                done_rdata <= wr_q ? '0 : rx_q[RX_W-1:2];
                done_err   <= wr_q ? (rx_q[1:0] != tx_q[1:0])
                                   : (rx_q[1:0] != {rd_par, ~rd_par});
            end
        end
    end

    assign tx_sh      = tx_q << pos_q;
    assign line_oe    = (st_q == ST_RUN) && (role == ROLE_DRIVE);
    assign line_out   = line_oe & tx_sh[TX_W-1];
    assign req_ready  = (st_q == ST_IDLE);
    assign timer_load = accept;
    assign timer_run  = (st_q == ST_RUN);

    AST_GUARD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && pos_q == POS_GUARD_TURN) |-> !line_oe); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |-> (pos_q <= POS_LAST_WR)); // R8
    AST_READY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready); // R8

endmodule

// File: rtl/swire_master.sv
// Top of the single-wire register access master. Connects the bit timer,
// the line receiver and the frame sequencer. The caller provides the
// external tri-state driver using line_oe and line_out, and feeds the wire
// level back on line_in.
module swire_master #(
    parameter int PER_W       = 11,
    parameter int PER_MIN     = 4,
    parameter int PER_MAX     = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] bit_period,
    input  logic             irq_act_high,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [4:0]       req_addr,
    input  logic [7:0]       req_wdata,
    output logic             done,
    output logic [7:0]       done_rdata,
    output logic             done_err,
    output logic             irq_event,
    input  logic             line_in,
    output logic             line_oe,
    output logic             line_out
);

    logic timer_load;
    logic timer_run;
    logic bit_mid;
    logic bit_last;
    logic line_s;

    swire_bit_timer #(
        .PER_W  (PER_W),
        .PER_MIN(PER_MIN),
        .PER_MAX(PER_MAX)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .period_in(bit_period),
        .run      (timer_run),
        .bit_mid  (bit_mid),
        .bit_last (bit_last)
    );

    swire_line_rx #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (line_in),
        .act_lvl  (irq_act_high),
        .monitor  (req_ready),
        .line_s   (line_s),
        .irq_event(irq_event)
    );

    swire_frame_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .act_lvl   (irq_act_high),
        .line_s    (line_s),
        .bit_mid   (bit_mid),
        .bit_last  (bit_last),
        .req_ready (req_ready),
        .timer_load(timer_load),
        .timer_run (timer_run),
        .line_oe   (line_oe),
        .line_out  (line_out),
        .done      (done),
        .done_rdata(done_rdata),
        .done_err  (done_err)
    );

    AST_IRQ_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_event |-> $past(req_ready)); // R10

endmodule

// File: tb/tb_swire_master.sv
// Self-checking bench: sweeps every address for reads and writes under both
// polarities and several bit periods, models the far end on the wire, and
// adds broken parity and acknowledge frames, period clamping and interrupts.
module tb_swire_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] bit_period = 11'd4;
    logic        act_high = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        s_en = 1'b0;
    logic        s_val = 1'b0;
    wire         req_ready, done, done_err, irq_event, line_oe, line_out;
    wire  [7:0]  done_rdata;
    wire         line_in = line_oe ? line_out : (s_en ? s_val : ~act_high);

    int errors = 0;
    int checks = 0;
    int irq_cnt = 0;

    always #10 clk = ~clk;

    swire_master dut (
        .clk(clk), .rst_n(rst_n), .bit_period(bit_period), .irq_act_high(act_high),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
        .done_rdata(done_rdata), .done_err(done_err), .irq_event(irq_event),
        .line_in(line_in), .line_oe(line_oe), .line_out(line_out)
    );

    always @(posedge clk) if (rst_n && irq_event) irq_cnt <= irq_cnt + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One complete frame with the far end modelled on the wire.
    task automatic run_frame(input bit wr, input logic [4:0] a, input logic [7:0] d,
                             input int per_in, input bit bad);
        int per = (per_in < 4) ? 4 : ((per_in > 1024) ? 1024 : per_in);
        int len = wr ? 27 : 24;
        logic [2:0]  op = wr ? 3'b011 : 3'b110;
        logic        p = ^{op, a, d};
        logic [21:0] tx = {act_high, ~act_high, act_high, op, a, 1'b0, d, p, ~p};
        int irq0;
        string tag;
        @(negedge clk);
        bit_period = 11'(per_in);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_wdata = wr ? d : 8'h5A;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        irq0 = irq_cnt;
        for (int k = 0; k < len; k++) begin
            s_en = 1'b0; s_val = 1'b0;
            if (!wr && k >= 12 && k <= 21) begin
                s_en = 1'b1; s_val = tx[21-k];
                if (bad && k == 20) s_val = ~s_val;
            end
            if (wr && (k == 23 || k == 24)) begin
                s_en = 1'b1; s_val = (k == 23) ? p : ~p;
                if (bad && k == 24) s_val = ~s_val;
            end
            for (int j = 0; j < per; j++) begin
                if (j == per / 2) begin
                    bit drv = (k < 11) || (wr && k >= 12 && k <= 21);
                    tag = (k < 3) ? "R2" : (k < 11) ? "R3" : drv ? "R5" : "R4";
                    check(line_oe == drv, drv ? tag : "R4", line_oe, drv);
                    if (drv) check(line_out == tx[21-k], tag, line_out, tx[21-k]);
                    check(!req_ready && !done, "R8", {req_ready, done}, 0);
                end
                @(negedge clk);
            end
        end
        s_en = 1'b0;
        check(done == 1'b1, "R8", done, 1);
        check(req_ready == 1'b1, "R8", req_ready, 1);
        check(done_rdata == (wr ? 8'h00 : d), wr ? "R7" : "R6", done_rdata, wr ? 0 : d);
        check(done_err == bad, wr ? "R7" : "R6", done_err, bad);
        check(irq_cnt == irq0, "R10", irq_cnt, irq0);
        @(negedge clk);
        check(done == 1'b0, "R8", done, 0);
    endtask

    task automatic pulse_irq(input int width);
        int irq0 = irq_cnt;
        @(negedge clk);
        s_en = 1'b1; s_val = act_high;
        repeat (width) @(negedge clk);
        s_en = 1'b0;
        repeat (6) @(negedge clk);
        check(irq_cnt == irq0 + 1, "R10", irq_cnt, irq0 + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", req_ready, 1);
        check(line_oe == 1'b0, "R1", line_oe, 0);
        check(done == 1'b0, "R1", done, 0);
        check(irq_event == 1'b0, "R1", irq_event, 0);

        for (int pol = 0; pol < 2; pol++) begin
            act_high = pol[0];
            repeat (8) @(negedge clk);
            pulse_irq(4);
            for (int a = 0; a < 32; a++) begin
                logic [7:0] d = 8'((a * 37 + pol * 91 + 5) & 255);
                run_frame(1'b1, 5'(a), d, 4 + (a % 4), 1'b0);
                run_frame(1'b0, 5'(a), ~d, 4 + ((a + 1) % 4), 1'b0);
            end
            pulse_irq(4);
        end

        // R6 / R7: broken check bits from the far end
        run_frame(1'b0, 5'd5, 8'h3C, 6, 1'b1);
        run_frame(1'b1, 5'd9, 8'hA5, 4, 1'b1);
        // R9: clamping below and above the window
        run_frame(1'b1, 5'd3, 8'h81, 2, 1'b0);
        run_frame(1'b0, 5'd30, 8'h7E, 2000, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule